// File: doc/BRIEF.md
# Delta-Panel Scan Timing Generator

This block sequences the logic-level drive timing for a small thin-film panel whose row and column drivers are shift registers built into the glass, and whose colour dots sit in a delta layout. It runs from a clock at twice the dot rate, so one tick is half a dot. Frame and line sync pulses come from the video front end. For the column driver it produces a start pulse and a pair of complementary column clocks. For the row driver it produces a start pulse, a pair of complementary row clocks and a gate enable. It also produces a clear pulse, a latched scan-direction level, a per-line video polarity flag and three strobes that time the external red, green and blue sample-and-hold stages.

Each active line carries one column clock pulse for every three dots, because the three colours are sampled together. Rows with an odd index start their column timing 1.5 dots (three ticks) later than even rows, which follows the delta arrangement. A hold request given with a line sync drops that line: the row driver does not advance and the gate enable stays low. This lets a source with more lines per field, such as PAL, be fitted to the panel.

Line position p counts the ticks since the edge that sampled `line_sync_i`. That edge gives p = 0. The outputs derived from p are registered, so the value seen after the k-th edge past the sync edge belongs to p = k-1. The row outputs, the polarity flag and the direction level change on the sync edge itself.

Top module: `delta_scan_gen`

## Requirements
- R1: On an active line, `hst_o` is high for PER = 6 ticks, for p from B to B+5. B = H_START (16) on even rows and H_START+SHIFT_HD (19) on odd rows.
- R2: On an active line, `hck_a_o` rises exactly N_PULSES (174) times. The first rise is at p = B+3, while `hst_o` is high. Each period is high 3 ticks and low 3 ticks. `hck_b_o` is always the inverse of `hck_a_o`.
- R3: The column timing of a row with an odd index is delayed by SHIFT_HD = 3 ticks (1.5 dots) relative to a row with an even index.
- R4: Each column clock period has three single-tick strobes, at offsets 0, 2 and 4 from the rise of `hck_a_o`. With `dir_o` = 1 the order is blue, red, green. With `dir_o` = 0, blue and green swap, giving green, red, blue. At most one strobe is high at a time.
- R5: `dir_o` (1 = left-to-right, 0 = right-to-left) takes `dir_right_i` only at a line sync. It holds between line syncs.
- R6: `frame_sync_i` sets `vst_o` = 1, `vck_a_o` = 1 and `vck_b_o` = 0. Each counted line sync whose row index is below V_LINES toggles both row clocks. The first counted line of a field is row 0, and its toggle gives the rising edge of `vck_b_o`. `vst_o` falls at the second counted line sync. A field gives V_LINES toggles.
- R7: A line sync with `hold_line_i` = 1 is not counted. It causes no row clock toggle and no column activity, and it leaves the row index unchanged. `gate_en_o` stays low from p = 0 until the next line sync.
- R8: On an active line, `gate_en_o` is low for p below EN_GAP (4). Otherwise it is high, except during a held line.
- R9: On an active line, `clr_o` is high for p from CLR_AT (4) to CLR_AT+CLR_LEN-1 (11). This is always before `hst_o` rises.
- R10: `pol_o` inverts at every line sync, held or not.
- R11: When `frame_sync_i` and `line_sync_i` are high in the same cycle, that line is row 0 of the new field. It leaves `vck_a_o` = 0 and `vst_o` = 1.
- R12: Line syncs beyond V_LINES rows give inactive lines. These have no column pulses, no row clock toggle, and `gate_en_o` high.
- R13: Synchronous active-high reset gives `hck_a_o`=0, `hck_b_o`=1, `hst_o`=0, `vst_o`=0, `vck_a_o`=1, `vck_b_o`=0, `gate_en_o`=1, `clr_o`=0, `dir_o`=1, `pol_o`=0 and all strobes 0. Lines stay inactive until a frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the dot rate |
| rst | input | 1 | Synchronous reset, active high |
| frame_sync_i | input | 1 | One-cycle field start pulse |
| line_sync_i | input | 1 | One-cycle line start pulse |
| hold_line_i | input | 1 | With line sync: drop this line |
| dir_right_i | input | 1 | Requested scan direction, 1 = left-to-right |
| hst_o | output | 1 | Column driver start pulse |
| hck_a_o | output | 1 | Column clock, first phase |
| hck_b_o | output | 1 | Column clock, second phase |
| vst_o | output | 1 | Row driver start pulse |
| vck_a_o | output | 1 | Row clock, first phase |
| vck_b_o | output | 1 | Row clock, second phase |
| gate_en_o | output | 1 | Row gate enable |
| clr_o | output | 1 | Gate clear pulse |
| dir_o | output | 1 | Latched scan direction |
| pol_o | output | 1 | Video polarity flag |
| stb_r_o | output | 1 | Red sampling strobe |
| stb_g_o | output | 1 | Green sampling strobe |
| stb_b_o | output | 1 | Blue sampling strobe |

## Verification
A field restart and a line start can land in the same cycle. The design must then make that line row 0, force the row clock phase before toggling it, and keep the row start pulse high. The bench provokes this by pulsing both syncs together at the start of the second field. It checks that row clock level and start pulse level right after the edge, and the per-cycle reference model checks that the line's column timing uses even-row placement. A held line falls next to a direction change latched at a line sync. The bench checks that the enable stays low for the whole held line and that the following rows keep their odd/even placement.

// File: rtl/delta_scan_pkg.sv
package delta_scan_pkg;
  // context of the line currently being scanned, latched at line sync
  typedef struct packed {
    logic on;     // row index below field height, line counted
    logic odd;    // row index is odd: delayed column timing
    logic right;  // latched scan direction
    logic skip;   // line dropped by hold request
  } line_ctx_t;
endpackage

// File: rtl/delta_scan_line.sv
module delta_scan_line
  import delta_scan_pkg::*;
#(
  parameter int V_LINES = 218
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      frame_sync_i,
  input  logic      line_sync_i,
  input  logic      hold_line_i,
  input  logic      dir_right_i,
  output line_ctx_t ctx_o,
  output logic      vst_o,
  output logic      vck_a_o,
  output logic      vck_b_o,
  output logic      pol_o
);
  localparam int ROW_W = $clog2(V_LINES + 1);

  logic [ROW_W-1:0] row, row_nx;
  logic fresh, fresh_eff, on_nx;

  always_comb begin
    fresh_eff = fresh | frame_sync_i;
    row_nx    = row;
    if (fresh_eff)
      row_nx = '0;
    else if (row < ROW_W'(V_LINES))
      row_nx = row + 1'b1;
    on_nx = (row_nx < ROW_W'(V_LINES));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row     <= ROW_W'(V_LINES);
      fresh   <= 1'b0;
      ctx_o   <= '{on: 1'b0, odd: 1'b0, right: 1'b1, skip: 1'b0};
      vst_o   <= 1'b0;
      vck_a_o <= 1'b1;
      vck_b_o <= 1'b0;
      pol_o   <= 1'b0;
    end else begin
      if (frame_sync_i) begin
        fresh   <= 1'b1;
        vst_o   <= 1'b1;
        vck_a_o <= 1'b1;
        vck_b_o <= 1'b0;
      end
      if (line_sync_i) begin
        pol_o       <= ~pol_o;
        ctx_o.right <= dir_right_i;
        if (hold_line_i) begin
          ctx_o.skip <= 1'b1;
          ctx_o.on   <= 1'b0;
        end else begin
          ctx_o.skip <= 1'b0;
          ctx_o.on   <= on_nx;
          ctx_o.odd  <= row_nx[0];
          row        <= row_nx;
          fresh      <= 1'b0;
          if (on_nx) begin
            vck_a_o <= frame_sync_i ? 1'b0 : ~vck_a_o;
            vck_b_o <= frame_sync_i ? 1'b1 : ~vck_b_o;
          end
          if (!fresh_eff)
            vst_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/delta_scan_h.sv
module delta_scan_h
  import delta_scan_pkg::*;
#(
  parameter int N_PULSES       = 174,
  parameter int DOTS_PER_PULSE = 3,
  parameter int HD_PER_DOT     = 2,
  parameter int SHIFT_HD       = 3,
  parameter int H_START        = 16,
  parameter int EN_GAP         = 4,
  parameter int CLR_AT         = 4,
  parameter int CLR_LEN        = 8,
  parameter int LINE_MAX       = 2047,
  localparam int PER  = DOTS_PER_PULSE * HD_PER_DOT,
  localparam int PH_W = $clog2(PER)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line_sync_i,
  input  line_ctx_t       ctx_i,
  output logic            hst_o,
  output logic            hck_a_o,
  output logic            hck_b_o,
  output logic            en_o,
  output logic            clr_o,
  output logic            inreg_o,
  output logic [PH_W-1:0] ph_o
);
  localparam int HALF  = PER / 2;
  localparam int POS_W = $clog2(LINE_MAX + 1);
  localparam int PC_W  = $clog2(N_PULSES);

  logic [POS_W-1:0] pos, b_pos, go_pos;
  logic [PC_W-1:0]  pc;
  logic             reg_go, hck_nx;

  always_comb begin
    b_pos  = POS_W'(H_START) + (ctx_i.odd ? POS_W'(SHIFT_HD) : '0);
    go_pos = b_pos + POS_W'(HALF - 1);
    reg_go = ctx_i.on && (pos == go_pos);
    hck_nx = inreg_o && (ph_o < PH_W'(HALF));
  end

  // line position and pulse-region counters
  always_ff @(posedge clk) begin
    if (rst) begin
      pos     <= POS_W'(LINE_MAX);
      ph_o    <= '0;
      pc      <= '0;
      inreg_o <= 1'b0;
    end else if (line_sync_i) begin
      pos     <= '0;
      ph_o    <= '0;
      pc      <= '0;
      inreg_o <= 1'b0;
    end else begin
      if (pos != POS_W'(LINE_MAX))
        pos <= pos + 1'b1;
      if (reg_go) begin
        inreg_o <= 1'b1;
        ph_o    <= '0;
        pc      <= '0;
      end else if (inreg_o) begin
        if (ph_o == PH_W'(PER - 1)) begin
          ph_o <= '0;
          if (pc == PC_W'(N_PULSES - 1))
            inreg_o <= 1'b0;
          else
            pc <= pc + 1'b1;
        end else begin
          ph_o <= ph_o + 1'b1;
        end
      end
    end
  end

  // registered drive levels
  always_ff @(posedge clk) begin
    if (rst) begin
      hst_o   <= 1'b0;
      hck_a_o <= 1'b0;
      hck_b_o <= 1'b1;
      en_o    <= 1'b1;
      clr_o   <= 1'b0;
    end else begin
      hst_o   <= ctx_i.on && (pos >= b_pos) && (pos < b_pos + POS_W'(PER));
      hck_a_o <= hck_nx;
      hck_b_o <= ~hck_nx;
      en_o    <= !(ctx_i.skip || (ctx_i.on && (pos < POS_W'(EN_GAP))));
      clr_o   <= ctx_i.on && (pos >= POS_W'(CLR_AT)) &&
                 (pos < POS_W'(CLR_AT + CLR_LEN));
    end
  end
endmodule

// File: rtl/delta_scan_stb.sv
module delta_scan_stb #(
  parameter int PER  = 6,
  parameter int PH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inreg_i,
  input  logic [PH_W-1:0] ph_i,
  input  logic            right_i,
  output logic            stb_r_o,
  output logic            stb_g_o,
  output logic            stb_b_o
);
  localparam int STEP = PER / 3;

  logic [2:0] slot;

  for (genvar s = 0; s < 3; s++) begin : g_slot
    assign slot[s] = inreg_i && (ph_i == PH_W'(s * STEP));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_r_o <= 1'b0;
      stb_g_o <= 1'b0;
      stb_b_o <= 1'b0;
    end else begin
      stb_r_o <= slot[1];
      stb_b_o <= right_i ? slot[0] : slot[2];
      stb_g_o <= right_i ? slot[2] : slot[0];
    end
  end
endmodule

// File: rtl/delta_scan_gen.sv
module delta_scan_gen
  import delta_scan_pkg::*;
#(
  parameter int V_LINES        = 218,
  parameter int N_PULSES       = 174,
  parameter int DOTS_PER_PULSE = 3,
  parameter int HD_PER_DOT     = 2,
  parameter int SHIFT_HD       = 3,
  parameter int H_START        = 16,
  parameter int EN_GAP         = 4,
  parameter int CLR_AT         = 4,
  parameter int CLR_LEN        = 8,
  parameter int LINE_MAX       = 2047
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_sync_i,
  input  logic line_sync_i,
  input  logic hold_line_i,
  input  logic dir_right_i,
  output logic hst_o,
  output logic hck_a_o,
  output logic hck_b_o,
  output logic vst_o,
  output logic vck_a_o,
  output logic vck_b_o,
  output logic gate_en_o,
  output logic clr_o,
  output logic dir_o,
  output logic pol_o,
  output logic stb_r_o,
  output logic stb_g_o,
  output logic stb_b_o
);
  localparam int PER  = DOTS_PER_PULSE * HD_PER_DOT;
  localparam int PH_W = $clog2(PER);

  line_ctx_t       ctx;
  logic            inreg;
  logic [PH_W-1:0] ph;

  delta_scan_line #(.V_LINES(V_LINES)) line_i (
    .clk(clk), .rst(rst),
    .frame_sync_i(frame_sync_i), .line_sync_i(line_sync_i),
    .hold_line_i(hold_line_i), .dir_right_i(dir_right_i),
    .ctx_o(ctx), .vst_o(vst_o), .vck_a_o(vck_a_o), .vck_b_o(vck_b_o),
    .pol_o(pol_o)
  );

  delta_scan_h #(
    .N_PULSES(N_PULSES), .DOTS_PER_PULSE(DOTS_PER_PULSE),
    .HD_PER_DOT(HD_PER_DOT), .SHIFT_HD(SHIFT_HD), .H_START(H_START),
    .EN_GAP(EN_GAP), .CLR_AT(CLR_AT), .CLR_LEN(CLR_LEN),
    .LINE_MAX(LINE_MAX)
  ) h_i (
    .clk(clk), .rst(rst), .line_sync_i(line_sync_i), .ctx_i(ctx),
    .hst_o(hst_o), .hck_a_o(hck_a_o), .hck_b_o(hck_b_o),
    .en_o(gate_en_o), .clr_o(clr_o), .inreg_o(inreg), .ph_o(ph)
  );

  delta_scan_stb #(.PER(PER), .PH_W(PH_W)) stb_i (
    .clk(clk), .rst(rst), .inreg_i(inreg), .ph_i(ph),
    .right_i(ctx.right),
    .stb_r_o(stb_r_o), .stb_g_o(stb_g_o), .stb_b_o(stb_b_o)
  );

  assign dir_o = ctx.right;
endmodule

// File: rtl/delta_scan_chk.sv
module delta_scan_chk (
  input logic clk,
  input logic rst,
  input logic frame_sync_i,
  input logic line_sync_i,
  input logic hold_line_i,
  input logic hst_o,
  input logic vst_o,
  input logic vck_a_o,
  input logic gate_en_o,
  input logic clr_o,
  input logic dir_o,
  input logic pol_o,
  input logic stb_r_o,
  input logic stb_g_o,
  input logic stb_b_o
);
  p_vck_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!line_sync_i && !frame_sync_i) |=> $stable(vck_a_o));

  p_frame_vst_r6: assert property (@(posedge clk) disable iff (rst)
    frame_sync_i |=> vst_o);

  p_pol_flip_r10: assert property (@(posedge clk) disable iff (rst)
    line_sync_i |=> (pol_o != $past(pol_o)));

  p_dir_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !line_sync_i |=> $stable(dir_o));

  p_stb_single_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb_r_o, stb_g_o, stb_b_o}));

  p_clr_before_hst_r9: assert property (@(posedge clk) disable iff (rst)
    !(clr_o && hst_o));

  p_hold_en_low_r7: assert property (@(posedge clk) disable iff (rst)
    (line_sync_i && hold_line_i) |=> (!line_sync_i |=> !gate_en_o));
endmodule

bind delta_scan_gen delta_scan_chk chk_i (
  .clk(clk), .rst(rst), .frame_sync_i(frame_sync_i),
  .line_sync_i(line_sync_i), .hold_line_i(hold_line_i),
  .hst_o(hst_o), .vst_o(vst_o), .vck_a_o(vck_a_o),
  .gate_en_o(gate_en_o), .clr_o(clr_o), .dir_o(dir_o), .pol_o(pol_o),
  .stb_r_o(stb_r_o), .stb_g_o(stb_g_o), .stb_b_o(stb_b_o)
);

// File: tb/delta_scan_gen_tb_top.sv
module delta_scan_gen_tb_top;
  localparam int V_L  = 6;
  localparam int N_P  = 174;
  localparam int PER  = 6;
  localparam int SH   = 3;
  localparam int HS   = 16;
  localparam int EG   = 4;
  localparam int CA   = 4;
  localparam int CL   = 8;
  localparam int LMAX = 2047;
  localparam int LP   = 1100;

  logic clk = 1'b0, rst = 1'b1;
  logic fs = 1'b0, ls = 1'b0, hold = 1'b0, dir = 1'b1;
  logic hst_o, hck_a_o, hck_b_o, vst_o, vck_a_o, vck_b_o, gate_en_o, clr_o;
  logic dir_o, pol_o, stb_r_o, stb_g_o, stb_b_o;

  delta_scan_gen #(.V_LINES(V_L)) dut_i (
    .clk(clk), .rst(rst), .frame_sync_i(fs), .line_sync_i(ls),
    .hold_line_i(hold), .dir_right_i(dir),
    .hst_o(hst_o), .hck_a_o(hck_a_o), .hck_b_o(hck_b_o), .vst_o(vst_o),
    .vck_a_o(vck_a_o), .vck_b_o(vck_b_o), .gate_en_o(gate_en_o),
    .clr_o(clr_o), .dir_o(dir_o), .pol_o(pol_o),
    .stb_r_o(stb_r_o), .stb_g_o(stb_g_o), .stb_b_o(stb_b_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced at every rising edge
  int m_p = LMAX, m_row = V_L;
  bit m_fresh = 0, m_on = 0, m_odd = 0, m_right = 1, m_skip = 0;
  bit m_vck = 1, m_vst = 0, m_pol = 0, m_valid = 0;
  bit e_hst = 0, e_h1 = 0, e_en = 1, e_clr = 0, e_r = 0, e_g = 0, e_b = 0;

  always @(posedge clk) begin
    m_valid = 1;
    if (rst) begin
      m_p = LMAX; m_row = V_L; m_fresh = 0; m_on = 0; m_odd = 0;
      m_right = 1; m_skip = 0; m_vck = 1; m_vst = 0; m_pol = 0;
      e_hst = 0; e_h1 = 0; e_en = 1; e_clr = 0; e_r = 0; e_g = 0; e_b = 0;
    end else begin
      int b, r, ph;
      bit inr, was_fresh;
      b   = HS + (m_odd ? SH : 0);
      r   = m_p - (b + 3);
      inr = m_on && r >= 0 && r < PER * N_P;
      ph  = inr ? r % PER : -1;
      e_hst = m_on && m_p >= b && m_p < b + PER;
      e_h1  = inr && ph < 3;
      e_r   = inr && ph == 2;
      e_b   = inr && ph == (m_right ? 0 : 4);
      e_g   = inr && ph == (m_right ? 4 : 0);
      e_en  = !(m_skip || (m_on && m_p < EG));
      e_clr = m_on && m_p >= CA && m_p < CA + CL;
      if (fs) begin m_fresh = 1; m_vst = 1; m_vck = 1; end
      if (ls) begin
        m_p = 0; m_pol = !m_pol; m_right = dir;
        if (hold) begin
          m_skip = 1; m_on = 0;
        end else begin
          was_fresh = m_fresh;
          m_skip = 0;
          if (m_fresh) begin m_row = 0; m_fresh = 0; end
          else if (m_row < V_L) m_row++;
          m_on  = (m_row < V_L);
          m_odd = m_row[0];
          if (m_on) m_vck = !m_vck;
          if (!was_fresh) m_vst = 0;
        end
      end else if (m_p < LMAX) begin
        m_p++;
      end
    end
  end

  always @(negedge clk) begin
    if (m_valid && !finished) begin
      chk("R1 hst", hst_o, e_hst);
      chk("R2 hck_a", hck_a_o, e_h1);
      chk("R2 hck_b", hck_b_o, !e_h1);
      chk("R4 stb_r", stb_r_o, e_r);
      chk("R4 stb_g", stb_g_o, e_g);
      chk("R4 stb_b", stb_b_o, e_b);
      chk("R8 gate_en", gate_en_o, e_en);
      chk("R9 clr", clr_o, e_clr);
      chk("R5 dir", dir_o, m_right);
      chk("R6 vck_a", vck_a_o, m_vck);
      chk("R6 vck_b", vck_b_o, !m_vck);
      chk("R6 vst", vst_o, m_vst);
      chk("R10 pol", pol_o, m_pol);
    end
  end

  int vtog = 0;

  // one line: sync pulse, then LP observed cycles
  task automatic do_line(input bit h, input bit on, input bit odd,
                         input bit right, input bit flip_mid, input bit with_frame);
    bit vprev, prev_h;
    int hrise, hst_at, seq, nseen, enlow;
    @(negedge clk);
    ls = 1; hold = h; fs = with_frame; vprev = vck_a_o;
    @(negedge clk);
    ls = 0; hold = 0; fs = 0;
    hrise = 0; hst_at = -1; seq = 0; nseen = 0; enlow = 0; prev_h = hck_a_o;
    if (with_frame) begin
      chk("R11 vck_a after joint sync", vck_a_o, 0);
      chk("R11 vst after joint sync", vst_o, 1);
    end else begin
      chk("R6 row clock toggle", int'(vck_a_o != vprev), int'(on));
      if (vck_a_o != vprev) vtog++;
    end
    for (int i = 0; i < LP; i++) begin
      if (hck_a_o && !prev_h) hrise++;
      prev_h = hck_a_o;
      if (hst_o && hst_at < 0) hst_at = i;
      if (nseen < 3 && (stb_b_o || stb_r_o || stb_g_o)) begin
        seq = seq * 4 + (stb_b_o ? 1 : stb_r_o ? 2 : 3);
        nseen++;
      end
      if (i > 0 && !gate_en_o) enlow++;
      if (flip_mid && i == LP / 2) dir = ~dir;
      @(negedge clk);
    end
    chk(on ? "R2 hck rises per line" : "R12 no pulses on inactive line",
        hrise, on ? N_P : 0);
    chk("R3 hst start position", hst_at, on ? HS + (odd ? SH : 0) + 1 : -1);
    chk("R4 strobe order", seq, on ? (right ? 27 : 57) : 0);
    chk(h ? "R7 enable low over held line" : "R8 enable low ticks",
        enlow, h ? LP - 1 : (on ? EG : 0));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R13 reset idle",
        {hst_o, hck_a_o, hck_b_o, vst_o, vck_a_o, vck_b_o, gate_en_o, clr_o,
         dir_o, pol_o, stb_r_o, stb_g_o, stb_b_o}, 13'b0010101010000);
    rst = 0;
    // idle line before any field: inactive
    do_line(0, 0, 0, 1, 0, 0);
    // field 1, right scan, standalone frame sync
    @(negedge clk); fs = 1;
    @(negedge clk); fs = 0;
    chk("R6 vst after frame sync", vst_o, 1);
    chk("R6 vck_a after frame sync", vck_a_o, 1);
    vtog = 0;
    for (int r = 0; r < V_L; r++) do_line(0, 1, r[0], 1, 0, 0);
    chk("R6 toggles per field", vtog, V_L);
    do_line(0, 0, 0, 1, 0, 0);
    do_line(0, 0, 0, 1, 1, 0);  // R12 extra line; R5 direction flips mid-line
    // field 2, left scan, joint syncs, one held line
    do_line(0, 1, 0, 0, 0, 1);
    do_line(1, 0, 0, 0, 0, 0);
    for (int r = 1; r < V_L; r++) do_line(0, 1, r[0], 0, r == V_L - 1, 0);
    do_line(0, 0, 0, 1, 0, 0);
    // field 3, right scan again
    @(negedge clk); fs = 1;
    @(negedge clk); fs = 0;
    do_line(0, 1, 0, 1, 0, 0);
    do_line(0, 1, 1, 1, 0, 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule